// File: doc/BRIEF.md
# Gated Encoder Count Channel

This block is one counting channel for incremental position or pulse sensing. It accepts either two tracks 90 degrees apart from a quadrature encoder, or a pulse line with a separate direction line. A configuration field picks the evaluation: pulse/direction, or quadrature at one, two or four counts per encoder cycle. All four external inputs are brought into the clock domain through a synchronizer chain before any edge is looked for.

Counting runs only while an internal gate is open. That gate combines a software gate bit with a hardware gate state. The hardware gate state opens on a rising edge and closes on a falling edge of a gate input, and configuration can tell the block to disregard it. A rising edge on the latch input stores the live count in a capture register. A software load port presets the count. The channel output is either a plain software bit or a registered signed "count at or above threshold" flag.

Top module: `enc_gated_counter`

## Requirements
- R1: While reset is asserted and right after it is released, `count`, `latch_val`, `out_q` and `gate_open` are all zero.
- R2: The count changes through counting only while `gate_open` is 1. `gate_open` is `sw_gate` AND (hardware gate state OR NOT `cfg_hwgate_en`).
- R3: The hardware gate state becomes 1 on a 0-to-1 edge of the synchronized `hw_gate_in` and 0 on a 1-to-0 edge. When `cfg_hwgate_en` is 0, `hw_gate_in` has no effect on counting.
- R4: With `cfg_mode` = 0 (pulse/direction), each rising edge of `trk_a` adds 1 when `trk_b` is 0 and subtracts 1 when `trk_b` is 1, even if `trk_b` changes in the same cycle.
- R5: With `cfg_mode` = 1 (quadrature x1), only a rising `trk_a` edge counts: +1 when `trk_b` is 0, -1 when `trk_b` is 1.
- R6: With `cfg_mode` = 2 (quadrature x2), both edges of `trk_a` count: +1 when the new A differs from B, otherwise -1. Edges of `trk_b` alone do not count.
- R7: With `cfg_mode` = 3 (quadrature x4), every single-track change counts. The up sequence of (A,B) is 00, 10, 11, 01. A change of both tracks in the same sampled cycle is ignored in modes 1 to 3.
- R8: When `cfg_dir_inv` is 1, the counting direction is reversed in every mode.
- R9: A rising edge on `latch_in` copies the count into `latch_val`. The captured value is held until the next such edge, and a later load does not change it.
- R10: When `load` is 1, the count takes `load_val` on the next clock. A load wins over a count step in the same cycle.
- R11: When `cmp_en` is 1, `out_q` shows, one clock later, whether the signed count is greater than or equal to the signed `cmp_val`.
- R12: When `cmp_en` is 0, `out_q` follows `sw_out` one clock later.
- R13: The count is a signed two's-complement value that wraps: incrementing 0x7FFFFFFF gives 0x80000000, and decrementing 0x80000000 gives 0x7FFFFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_mode | input | 2 | 0 pulse/dir, 1 quad x1, 2 quad x2, 3 quad x4 |
| cfg_dir_inv | input | 1 | Reverse counting direction |
| cfg_hwgate_en | input | 1 | Use the hardware gate in the internal gate |
| sw_gate | input | 1 | Software gate bit |
| trk_a | input | 1 | Track A or pulse input (asynchronous) |
| trk_b | input | 1 | Track B or direction input (asynchronous) |
| hw_gate_in | input | 1 | Hardware gate input (asynchronous) |
| latch_in | input | 1 | Latch strobe input (asynchronous) |
| load | input | 1 | Synchronous preset strobe |
| load_val | input | CNT_W | Preset value |
| cmp_en | input | 1 | Select compare output instead of software bit |
| cmp_val | input | CNT_W | Signed compare threshold |
| sw_out | input | 1 | Software-driven output bit |
| count | output | CNT_W | Live signed count |
| latch_val | output | CNT_W | Captured count |
| gate_open | output | 1 | Internal gate state |
| out_q | output | 1 | Registered channel output |

## Verification
The bench builds the channel with its defaults: a 32-bit count and a two-stage synchronizer. The full width lets the load port place the count right at the signed boundaries, so the wrap in both directions and signed compare thresholds below zero can be exercised directly. The short synchronizer keeps the input-to-count delay to a few cycles, which lets one table walk all four evaluation modes, including same-cycle double transitions, within a small settle window.

// File: rtl/enc_gated_counter.sv
module enc_gated_counter #(
  parameter int CNT_W  = 32,
  parameter int SYNC_N = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [1:0]       cfg_mode,
  input  logic             cfg_dir_inv,
  input  logic             cfg_hwgate_en,
  input  logic             sw_gate,
  input  logic             trk_a,
  input  logic             trk_b,
  input  logic             hw_gate_in,
  input  logic             latch_in,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             cmp_en,
  input  logic [CNT_W-1:0] cmp_val,
  input  logic             sw_out,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] latch_val,
  output logic             gate_open,
  output logic             out_q
);

  localparam logic [1:0] M_PDIR = 2'd0;
  localparam logic [1:0] M_X1   = 2'd1;
  localparam logic [1:0] M_X2   = 2'd2;
  localparam logic [1:0] M_X4   = 2'd3;
  localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

  logic [SYNC_N-1:0] sa, sb, sg, sl;
  logic a_s, b_s, g_s, l_s;
  logic a_p, b_p, g_p, l_p;
  logic a_ed, b_ed, g_rise, g_fall, l_rise;
  logic hw_open;
  logic stp, up, dir;
  logic cmp_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sa <= '0;
      sb <= '0;
      sg <= '0;
      sl <= '0;
    end else begin
      sa <= {sa[SYNC_N-2:0], trk_a};
      sb <= {sb[SYNC_N-2:0], trk_b};
      sg <= {sg[SYNC_N-2:0], hw_gate_in};
      sl <= {sl[SYNC_N-2:0], latch_in};
    end
  end

  assign a_s = sa[SYNC_N-1];
  assign b_s = sb[SYNC_N-1];
  assign g_s = sg[SYNC_N-1];
  assign l_s = sl[SYNC_N-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_p <= 1'b0;
      b_p <= 1'b0;
      g_p <= 1'b0;
      l_p <= 1'b0;
    end else begin
      a_p <= a_s;
      b_p <= b_s;
      g_p <= g_s;
      l_p <= l_s;
    end
  end

  assign a_ed   = a_s ^ a_p;
  assign b_ed   = b_s ^ b_p;
  assign g_rise = g_s & ~g_p;
  assign g_fall = ~g_s & g_p;
  assign l_rise = l_s & ~l_p;

  always_comb begin
    stp = 1'b0;
    up  = 1'b0;
    case (cfg_mode)
      M_PDIR: if (a_ed && a_s) begin
        stp = 1'b1;
        up  = ~b_s;
      end
      M_X1: if (a_ed && a_s && !b_ed) begin
        stp = 1'b1;
        up  = ~b_s;
      end
      M_X2: if (a_ed && !b_ed) begin
        stp = 1'b1;
        up  = a_s ^ b_s;
      end
      M_X4: if (a_ed ^ b_ed) begin
        stp = 1'b1;
        up  = a_ed ? (a_s ^ b_s) : ~(a_s ^ b_s);
      end
      default: ;
    endcase
  end

  assign dir = up ^ cfg_dir_inv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      hw_open <= 1'b0;
    else if (g_rise) hw_open <= 1'b1;
    else if (g_fall) hw_open <= 1'b0;
  end

  assign gate_open = sw_gate & (hw_open | ~cfg_hwgate_en);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 count <= '0;
    else if (load)              count <= load_val;
    else if (gate_open && stp)  count <= dir ? count + ONE : count - ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      latch_val <= '0;
    else if (l_rise) latch_val <= count;
  end

  assign cmp_hit = $signed(count) >= $signed(cmp_val);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) out_q <= 1'b0;
    else        out_q <= cmp_en ? cmp_hit : sw_out;
  end

  assert_closed_gate_holds_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!gate_open && !load) |=> (count == $past(count)));

  assert_single_step_R13: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ((count == $past(count)) || (count == $past(count) + ONE) ||
               (count == $past(count) - ONE)));

  assert_hw_open_on_rise_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hw_open) |-> ($past(g_s) && !$past(g_p)));

  assert_hw_close_on_fall_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hw_open) |-> (!$past(g_s) && $past(g_p)));

  assert_latch_capture_R9: assert property (@(posedge clk) disable iff (!rst_n)
    l_rise |=> (latch_val == $past(count)));

  assert_latch_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !l_rise |=> $stable(latch_val));

  assert_load_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> (count == $past(load_val)));

  assert_direct_out_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_en |=> (out_q == $past(sw_out)));

  assert_double_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (a_ed && b_ed && cfg_mode != M_PDIR && !load) |=> (count == $past(count)));

endmodule

// File: tb/test_enc_gated_counter.sv
`timescale 1ns/1ps
module test_enc_gated_counter;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  cfg_mode = 2'd3;
  logic        cfg_dir_inv = 1'b0;
  logic        cfg_hwgate_en = 1'b0;
  logic        sw_gate = 1'b0;
  logic        trk_a = 1'b0;
  logic        trk_b = 1'b0;
  logic        hw_gate_in = 1'b0;
  logic        latch_in = 1'b0;
  logic        load = 1'b0;
  logic [31:0] load_val = '0;
  logic        cmp_en = 1'b0;
  logic [31:0] cmp_val = '0;
  logic        sw_out = 1'b0;
  logic [31:0] count, latch_val;
  logic        gate_open, out_q;

  int total = 0;
  int bad = 0;

  always #2.5 clk = ~clk;

  enc_gated_counter i_enc_gated_counter (
    .clk(clk), .rst_n(rst_n), .cfg_mode(cfg_mode), .cfg_dir_inv(cfg_dir_inv),
    .cfg_hwgate_en(cfg_hwgate_en), .sw_gate(sw_gate), .trk_a(trk_a), .trk_b(trk_b),
    .hw_gate_in(hw_gate_in), .latch_in(latch_in), .load(load), .load_val(load_val),
    .cmp_en(cmp_en), .cmp_val(cmp_val), .sw_out(sw_out), .count(count),
    .latch_val(latch_val), .gate_open(gate_open), .out_q(out_q)
  );

  // entry: {mode[1:0], a, b, expected count as signed 8 bits}
  localparam int NV = 26;
  localparam logic [11:0] VEC [0:NV-1] = '{
    {2'd3, 1'b1, 1'b0, 8'd1}, {2'd3, 1'b1, 1'b1, 8'd2}, {2'd3, 1'b0, 1'b1, 8'd3},
    {2'd3, 1'b0, 1'b0, 8'd4}, {2'd3, 1'b0, 1'b1, 8'd3}, {2'd3, 1'b1, 1'b1, 8'd2},
    {2'd3, 1'b1, 1'b0, 8'd1}, {2'd3, 1'b0, 1'b0, 8'd0}, {2'd3, 1'b1, 1'b1, 8'd0},
    {2'd2, 1'b0, 1'b1, 8'd1}, {2'd2, 1'b0, 1'b0, 8'd1}, {2'd2, 1'b1, 1'b0, 8'd2},
    {2'd2, 1'b1, 1'b1, 8'd2}, {2'd2, 1'b0, 1'b1, 8'd3},
    {2'd1, 1'b0, 1'b0, 8'd3}, {2'd1, 1'b1, 1'b0, 8'd4}, {2'd1, 1'b0, 1'b0, 8'd4},
    {2'd1, 1'b1, 1'b1, 8'd4}, {2'd1, 1'b0, 1'b1, 8'd4}, {2'd1, 1'b1, 1'b1, 8'd3},
    {2'd0, 1'b0, 1'b0, 8'd3}, {2'd0, 1'b1, 1'b1, 8'd2}, {2'd0, 1'b0, 1'b1, 8'd2},
    {2'd0, 1'b1, 1'b1, 8'd1}, {2'd0, 1'b0, 1'b0, 8'd1}, {2'd0, 1'b1, 1'b0, 8'd2}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    for (int k = 0; k < n; k++) @(negedge clk);
  endtask

  task automatic set_ab(input logic a, input logic b);
    trk_a = a;
    trk_b = b;
    cyc(6);
  endtask

  task automatic pulse_a();
    set_ab(1'b1, trk_b);
    set_ab(1'b0, trk_b);
  endtask

  task automatic do_load(input logic [31:0] v);
    load_val = v;
    load = 1'b1;
    cyc(1);
    load = 1'b0;
    cyc(2);
  endtask

  initial begin
    #1000000;
    bad++;
    total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    cyc(3);
    chk(count == 0 && latch_val == 0 && out_q == 0 && gate_open == 0, "R1 reset", count, 0);
    rst_n = 1'b1;
    cyc(2);
    chk(count == 0 && latch_val == 0 && out_q == 0, "R1 after release", count, 0);

    sw_gate = 1'b1;
    cyc(2);
    for (int i = 0; i < NV; i++) begin
      cfg_mode = VEC[i][11:10];
      set_ab(VEC[i][9], VEC[i][8]);
      chk($signed(count) == $signed(VEC[i][7:0]),
          $sformatf("R4/R5/R6/R7 vec%0d mode%0d", i, VEC[i][11:10]),
          count, {{24{VEC[i][7]}}, VEC[i][7:0]});
    end

    // mode 0, A=1 B=0, count 2
    set_ab(1'b0, 1'b0);
    sw_gate = 1'b0;
    cyc(1);
    chk(gate_open == 1'b0, "R2 gate closed", gate_open, 0);
    pulse_a();
    chk(count == 2, "R2 no count with closed gate", count, 2);
    sw_gate = 1'b1;
    cfg_hwgate_en = 1'b1;
    cyc(2);
    pulse_a();
    chk(count == 2, "R3 hw gate not yet opened", count, 2);
    hw_gate_in = 1'b1;
    cyc(6);
    chk(gate_open == 1'b1, "R3 hw gate opened", gate_open, 1);
    pulse_a();
    chk(count == 3, "R3 counting with hw gate open", count, 3);
    hw_gate_in = 1'b0;
    cyc(6);
    pulse_a();
    chk(count == 3, "R3 hw gate closed by falling edge", count, 3);
    cfg_hwgate_en = 1'b0;
    cyc(2);
    pulse_a();
    chk(count == 4, "R3 hw gate input ignored when disabled", count, 4);

    cfg_dir_inv = 1'b1;
    pulse_a();
    chk(count == 3, "R8 inverted direction", count, 3);
    cfg_dir_inv = 1'b0;

    do_load(32'd1000);
    chk(count == 1000, "R10 load", count, 1000);
    latch_in = 1'b1;
    cyc(6);
    chk(latch_val == 1000, "R9 latch capture", latch_val, 1000);
    latch_in = 1'b0;
    cyc(4);
    do_load(32'd5);
    chk(latch_val == 1000 && count == 5, "R9 latch holds after load", latch_val, 1000);

    do_load(32'h7FFF_FFFF);
    pulse_a();
    chk(count == 32'h8000_0000, "R13 wrap up", count, 32'h8000_0000);
    trk_b = 1'b1;
    cyc(6);
    pulse_a();
    chk(count == 32'h7FFF_FFFF, "R13 wrap down", count, 32'h7FFF_FFFF);
    trk_b = 1'b0;
    cyc(6);

    cmp_en = 1'b1;
    cmp_val = -32'sd3;
    do_load(-32'sd5);
    chk(out_q == 1'b0, "R11 below threshold", out_q, 0);
    do_load(-32'sd3);
    chk(out_q == 1'b1, "R11 equal threshold", out_q, 1);
    do_load(32'd100);
    chk(out_q == 1'b1, "R11 above threshold", out_q, 1);
    do_load(32'h8000_0000);
    chk(out_q == 1'b0, "R11 most negative", out_q, 0);

    cmp_en = 1'b0;
    sw_out = 1'b1;
    cyc(2);
    chk(out_q == 1'b1, "R12 direct high", out_q, 1);
    sw_out = 1'b0;
    cyc(2);
    chk(out_q == 1'b0, "R12 direct low", out_q, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule